// File: doc/BRIEF.md
# Contactless Card Session Sequencer

This block runs a reader-side session with a short-range contactless memory card. It sits above a bit transmitter, a bit demodulator and a keystream generator, and drives them through start/done hooks. It does none of the RF work itself. When asked to open a session, it turns the field on and lets the card charge. It then runs a three-frame exchange: a fixed initialisation value goes out in the clear, the card answers with a 6-bit type code, and the block returns an acknowledge chosen by that code. The type code fixes the card's address width, which sets the length of every later command.

Once a session is open, the block takes single-byte read or write requests. Each command frame carries a 4-bit checksum that the block computes one bit per cycle. A read response is checked against the same checksum. A write is confirmed by one plain (not descrambled) acknowledge bit, which must arrive within a bounded number of bit periods. Between frames the block tells the keystream generator how far to step, so that both ends stay in lock-step. Each finished operation gives a one-cycle result pulse with an error flag and, for reads, the data byte.

Top module: `card_session_seq`

## Requirements
- R1: On `sessStart` the carrier turns on and stays on for `POWER_CYCLES` cycles before anything else happens. The hook order is then: keystream init, a 7-bit frame holding `SESSION_IV` (0x55 by default), keystream load of the initial value, an advance by 2, and a 6-bit receive.
- R2: A received type of 0x0D gives a 5-bit address, 0x1D gives 8 bits and 0x3D gives 10 bits. After an advance by 3 the block sends a 6-bit acknowledge: 0x19 for type 0x0D, 0x39 for the other two. It then reports success and raises `sessUp`.
- R3: Any other type code reports an error, sends no acknowledge, and drops both `sessUp` and the carrier.
- R4: A read sends frame `(addr<<1)|1` with length address width + 1, after a keystream advance by 2. Address bits above the card's width are dropped.
- R5: A read then advances the keystream by 2 and receives 12 bits: data in bits 7:0 and checksum in bits 11:8. If the checksum matches, it reports the data with no error, then advances by 1.
- R6: On a checksum mismatch the read reports an error with data 0x00 and does not advance the keystream afterwards.
- R7: The checksum is 4 bits with initial value 0x5 and no final inversion. It is fed LSB first with `(byte<<L)|cmd` over L+8 bits, where L is the command length. For each bit b the state s updates as s' = (s>>1) XOR (0xC if s[0]^b).
- R8: A write sends `cmd | data<<L | crc<<(L+8)`, where `cmd=(addr<<1)|0` and L = address width + 1. The frame is L+12 bits long. The keystream advances by 2 before the frame and by 3 after it.
- R9: After a write frame, a 1 on `rawBit` at any of the first `ACK_WINDOW` (60) `rawBitValid` periods reports success. If all of those periods show 0, the write reports an error.
- R10: A write whose masked address is 4 or less is refused at once with an error, and no frame is sent.
- R11: In and after reset, `sessUp`, `carrierOn`, `resValid`, `resErr`, `resData` and every hook strobe are low or zero.
- R12: `cmdStart` with no session open is ignored: it produces no frame and no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sessStart | input | 1 | Open (or reopen) a session |
| cmdStart | input | 1 | Issue a command while a session is open |
| cmdWrite | input | 1 | 1 = write, 0 = read |
| cmdAddr | input | ADDR_W | Byte address |
| cmdData | input | 8 | Write data |
| resValid | output | 1 | One-cycle result strobe |
| resErr | output | 1 | Result is an error |
| resData | output | 8 | Read data, zero otherwise |
| sessUp | output | 1 | Session open and idle |
| cardType | output | 6 | Last received type code |
| carrierOn | output | 1 | Field enable |
| txStart | output | 1 | Start of a transmit frame |
| txFrame | output | ADDR_W+13 | Frame bits, bit 0 sent first |
| txLen | output | 5 | Frame length in bits |
| txDone | input | 1 | Transmit finished |
| rxStart | output | 1 | Start of a receive frame |
| rxLen | output | 4 | Bits to receive |
| rxDone | input | 1 | Receive finished, `rxData` valid |
| rxData | input | 12 | Descrambled received bits |
| rawBitValid | input | 1 | One pulse per bit period |
| rawBit | input | 1 | Plain sampled bit |
| ksInit | output | 1 | Keystream off / zero |
| ksLoad | output | 1 | Load keystream from `ksIv` |
| ksIv | output | 7 | Initial value for the keystream |
| ksAdv | output | 1 | Advance keystream |
| ksStep | output | 2 | Advance amount |

## Verification
The handshake is run with all three known type codes and with one unknown code. This separates the address-width and acknowledge choices from one another and from the error path. Reads are driven from a table that covers low, high, all-ones and all-zero addresses and data. Some entries have a corrupted checksum, so a wrong bit order or polynomial in the checksum shows up separately from a missed mismatch. Writes are tried with the acknowledge bit early, on the last allowed period, and one period too late. They are also tried with addresses on both sides of the protected range. An oversized address is used on the smallest card to expose missing masking.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;

  localparam logic [3:0] CRC_POLY = 4'hC;
  localparam logic [3:0] CRC_INIT = 4'h5;

  typedef enum logic [1:0] {TX_IV, TX_ACK, TX_READ, TX_WRITE} txSel_t;
  typedef enum logic [1:0] {CNT_POWER, CNT_CRC, CNT_ACK} cntSel_t;

  typedef enum logic [4:0] {
    S_IDLE, S_POWER, S_KS_OFF, S_IV_TX, S_IV_WAIT, S_KS_LOAD, S_KS_ADV2,
    S_TYPE_RX, S_TYPE_WAIT, S_TYPE_CHK, S_ACK_ADV3, S_ACK_TX, S_ACK_WAIT,
    S_READY,
    S_RD_ADV2, S_RD_TX, S_RD_TXW, S_RD_ADV2B, S_RD_RX, S_RD_RXW,
    S_RD_CRCLD, S_RD_CRC, S_RD_CHK,
    S_WR_CRCLD, S_WR_CRC, S_WR_ADV2, S_WR_TX, S_WR_TXW, S_WR_ADV3, S_WR_ACKW
  } seqState_t;

  typedef struct packed {
    logic    cntLoad;
    cntSel_t cntSel;
    logic    cntDec;
    logic    crcLoad;
    logic    crcShift;
    logic    typeLatch;
    logic    rspLatch;
    logic    cmdLatch;
    logic    resOk;
    logic    resRead;
    logic    resFail;
    txSel_t  txSel;
  } seqStrobe_t;

  typedef struct packed {
    logic cntIsOne;
    logic typeKnown;
    logic crcMatch;
    logic writeAllowed;
  } seqStatus_t;

endpackage

// File: rtl/card_seq_ctrl.sv
module card_seq_ctrl
  import card_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sessStart,
  input  logic       cmdStart,
  input  logic       cmdWrite,
  input  logic       txDone,
  input  logic       rxDone,
  input  logic       rawBitValid,
  input  logic       rawBit,
  input  seqStatus_t sts,
  output seqStrobe_t stb,
  output logic       txStart,
  output logic       rxStart,
  output logic [3:0] rxLen,
  output logic       ksInit,
  output logic       ksLoad,
  output logic       ksAdv,
  output logic [1:0] ksStep,
  output logic       sessUp,
  output logic       carrierOn
);

  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  assign sessUp    = (state == S_READY);
  assign carrierOn = (state != S_IDLE);  // R1 R3

  always_comb begin
    nextState = state;
    stb       = '0;
    stb.txSel = TX_IV;
    txStart   = 1'b0;
    rxStart   = 1'b0;
    rxLen     = 4'd6;
    ksInit    = 1'b0;
    ksLoad    = 1'b0;
    ksAdv     = 1'b0;
    ksStep    = 2'd0;
    unique case (state)
      S_IDLE: if (sessStart) begin
        stb.cntLoad = 1'b1; stb.cntSel = CNT_POWER; nextState = S_POWER;
      end
      S_POWER: begin
        if (sts.cntIsOne) nextState = S_KS_OFF;
        else stb.cntDec = 1'b1;
      end
      S_KS_OFF:  begin ksInit = 1'b1; nextState = S_IV_TX; end
      S_IV_TX:   begin txStart = 1'b1; nextState = S_IV_WAIT; end
      S_IV_WAIT: if (txDone) nextState = S_KS_LOAD;
      S_KS_LOAD: begin ksLoad = 1'b1; nextState = S_KS_ADV2; end
      S_KS_ADV2: begin ksAdv = 1'b1; ksStep = 2'd2; nextState = S_TYPE_RX; end
      S_TYPE_RX: begin rxStart = 1'b1; nextState = S_TYPE_WAIT; end
      S_TYPE_WAIT: if (rxDone) begin stb.typeLatch = 1'b1; nextState = S_TYPE_CHK; end
      S_TYPE_CHK: begin
        if (sts.typeKnown) nextState = S_ACK_ADV3;
        else begin stb.resFail = 1'b1; nextState = S_IDLE; end  // R3
      end
      S_ACK_ADV3: begin ksAdv = 1'b1; ksStep = 2'd3; nextState = S_ACK_TX; end
      S_ACK_TX: begin txStart = 1'b1; stb.txSel = TX_ACK; nextState = S_ACK_WAIT; end
      S_ACK_WAIT: begin
        stb.txSel = TX_ACK;
        if (txDone) begin stb.resOk = 1'b1; nextState = S_READY; end
      end
      S_READY: begin
        if (sessStart) begin
          stb.cntLoad = 1'b1; stb.cntSel = CNT_POWER; nextState = S_POWER;
        end else if (cmdStart) begin
          stb.cmdLatch = 1'b1;
          if (!cmdWrite)             nextState = S_RD_ADV2;
          else if (sts.writeAllowed) nextState = S_WR_CRCLD;
          else                       stb.resFail = 1'b1;  // R10
        end
      end
      S_RD_ADV2:  begin ksAdv = 1'b1; ksStep = 2'd2; nextState = S_RD_TX; end
      S_RD_TX:    begin txStart = 1'b1; stb.txSel = TX_READ; nextState = S_RD_TXW; end
      S_RD_TXW:   begin stb.txSel = TX_READ; if (txDone) nextState = S_RD_ADV2B; end
      S_RD_ADV2B: begin ksAdv = 1'b1; ksStep = 2'd2; nextState = S_RD_RX; end
      S_RD_RX:    begin rxStart = 1'b1; rxLen = 4'd12; nextState = S_RD_RXW; end
      S_RD_RXW: begin
        rxLen = 4'd12;
        if (rxDone) begin stb.rspLatch = 1'b1; nextState = S_RD_CRCLD; end
      end
      S_RD_CRCLD: begin
        stb.crcLoad = 1'b1; stb.cntLoad = 1'b1; stb.cntSel = CNT_CRC; nextState = S_RD_CRC;
      end
      S_RD_CRC: begin
        stb.crcShift = 1'b1;
        if (sts.cntIsOne) nextState = S_RD_CHK;
        else stb.cntDec = 1'b1;
      end
      S_RD_CHK: begin
        nextState = S_READY;
        if (sts.crcMatch) begin ksAdv = 1'b1; ksStep = 2'd1; stb.resRead = 1'b1; end  // R5
        else stb.resFail = 1'b1;  // R6
      end
      S_WR_CRCLD: begin
        stb.crcLoad = 1'b1; stb.cntLoad = 1'b1; stb.cntSel = CNT_CRC; nextState = S_WR_CRC;
      end
      S_WR_CRC: begin
        stb.crcShift = 1'b1;
        if (sts.cntIsOne) nextState = S_WR_ADV2;
        else stb.cntDec = 1'b1;
      end
      S_WR_ADV2: begin ksAdv = 1'b1; ksStep = 2'd2; nextState = S_WR_TX; end
      S_WR_TX:   begin txStart = 1'b1; stb.txSel = TX_WRITE; nextState = S_WR_TXW; end
      S_WR_TXW:  begin stb.txSel = TX_WRITE; if (txDone) nextState = S_WR_ADV3; end
      S_WR_ADV3: begin
        ksAdv = 1'b1; ksStep = 2'd3;
        stb.cntLoad = 1'b1; stb.cntSel = CNT_ACK; nextState = S_WR_ACKW;
      end
      S_WR_ACKW: if (rawBitValid) begin  // R9
        if (rawBit) begin stb.resOk = 1'b1; nextState = S_READY; end
        else if (sts.cntIsOne) begin stb.resFail = 1'b1; nextState = S_READY; end
        else stb.cntDec = 1'b1;
      end
      default: nextState = S_IDLE;
    endcase
  end

endmodule

// File: rtl/card_seq_dp.sv
module card_seq_dp
  import card_seq_pkg::*;
#(
  parameter int         ADDR_W       = 10,
  parameter int         POWER_CYCLES = 5000,
  parameter int         ACK_WINDOW   = 60,
  parameter int         WRITE_FLOOR  = 4,
  parameter logic [6:0] SESSION_IV   = 7'h55
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          stb,
  output seqStatus_t          sts,
  input  logic                cmdWrite,
  input  logic [ADDR_W-1:0]   cmdAddr,
  input  logic [7:0]          cmdData,
  input  logic [11:0]         rxData,
  output logic                resValid,
  output logic                resErr,
  output logic [7:0]          resData,
  output logic [5:0]          cardType,
  output logic [ADDR_W+12:0]  txFrame,
  output logic [4:0]          txLen
);

  localparam int FRAME_W = ADDR_W + 13;
  localparam int CRC_W   = ADDR_W + 9;
  localparam int MAXC_A  = (POWER_CYCLES > ACK_WINDOW) ? POWER_CYCLES : ACK_WINDOW;
  localparam int MAXC    = (MAXC_A > CRC_W) ? MAXC_A : CRC_W;
  localparam int CNT_W   = $clog2(MAXC + 1);

  logic [5:0]        typeQ;
  logic [4:0]        addrSz, cmdLen;
  logic [5:0]        ackCode;
  logic [ADDR_W-1:0] addrMask, addrQ;
  logic [7:0]        dataQ, crcByte;
  logic              writeQ;
  logic [11:0]       rspQ;
  logic [ADDR_W:0]   cmdField;
  logic [CRC_W-1:0]  crcStream, shQ;
  logic [3:0]        crcQ;
  logic [CNT_W-1:0]  cntQ, cntInit;

  // R2 type code decode
  always_comb begin
    sts.typeKnown = 1'b1;
    addrSz  = 5'd0;
    ackCode = 6'h00;
    unique case (typeQ)
      6'h0D:   begin addrSz = 5'd5;  ackCode = 6'h19; end
      6'h1D:   begin addrSz = 5'd8;  ackCode = 6'h39; end
      6'h3D:   begin addrSz = 5'd10; ackCode = 6'h39; end
      default: sts.typeKnown = 1'b0;
    endcase
  end

  assign cmdLen   = addrSz + 5'd1;
  assign addrMask = ADDR_W'((FRAME_W'(1) << addrSz) - FRAME_W'(1));  // R4
  assign sts.writeAllowed = ((cmdAddr & addrMask) > ADDR_W'(WRITE_FLOOR));
  assign cmdField  = {addrQ & addrMask, ~writeQ};
  assign crcByte   = writeQ ? dataQ : rspQ[7:0];
  assign crcStream = CRC_W'(cmdField) | (CRC_W'(crcByte) << cmdLen);
  assign sts.crcMatch = (crcQ == rspQ[11:8]);
  assign sts.cntIsOne = (cntQ == CNT_W'(1));
  assign cardType = typeQ;

  always_comb begin
    unique case (stb.cntSel)
      CNT_POWER: cntInit = CNT_W'(POWER_CYCLES);
      CNT_CRC:   cntInit = CNT_W'(cmdLen) + CNT_W'(8);
      default:   cntInit = CNT_W'(ACK_WINDOW);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      typeQ <= '0; addrQ <= '0; dataQ <= '0; writeQ <= 1'b0;
      rspQ <= '0; cntQ <= '0; crcQ <= CRC_INIT; shQ <= '0;
    end else begin
      if (stb.typeLatch) typeQ <= rxData[5:0];
      if (stb.rspLatch)  rspQ  <= rxData;
      if (stb.cmdLatch) begin
        addrQ <= cmdAddr; dataQ <= cmdData; writeQ <= cmdWrite;
      end
      if (stb.cntLoad)     cntQ <= cntInit;
      else if (stb.cntDec) cntQ <= cntQ - CNT_W'(1);
      // R7 serial checksum, LSB first
      if (stb.crcLoad) begin
        crcQ <= CRC_INIT;
        shQ  <= crcStream;
      end else if (stb.crcShift) begin
        crcQ <= {1'b0, crcQ[3:1]} ^ ((crcQ[0] ^ shQ[0]) ? CRC_POLY : 4'h0);
        shQ  <= shQ >> 1;
      end
    end
  end

  // R1 R2 R4 R8 frame assembly
  always_comb begin
    unique case (stb.txSel)
      TX_IV:    begin txFrame = FRAME_W'(SESSION_IV); txLen = 5'd7; end
      TX_ACK:   begin txFrame = FRAME_W'(ackCode);    txLen = 5'd6; end
      TX_READ:  begin txFrame = FRAME_W'(cmdField);   txLen = cmdLen; end
      default: begin
        txFrame = FRAME_W'(cmdField) | (FRAME_W'(dataQ) << cmdLen)
                | (FRAME_W'(crcQ) << (cmdLen + 5'd8));
        txLen   = cmdLen + 5'd12;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0; resErr <= 1'b0; resData <= 8'h00;
    end else begin
      resValid <= stb.resOk | stb.resRead | stb.resFail;
      if (stb.resFail)      begin resErr <= 1'b1; resData <= 8'h00; end  // R6
      else if (stb.resRead) begin resErr <= 1'b0; resData <= rspQ[7:0]; end
      else if (stb.resOk)   begin resErr <= 1'b0; resData <= 8'h00; end
    end
  end

endmodule

// File: rtl/card_session_seq.sv
module card_session_seq
  import card_seq_pkg::*;
#(
  parameter int         ADDR_W       = 10,
  parameter int         POWER_CYCLES = 5000,
  parameter int         ACK_WINDOW   = 60,
  parameter int         WRITE_FLOOR  = 4,
  parameter logic [6:0] SESSION_IV   = 7'h55
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sessStart,
  input  logic               cmdStart,
  input  logic               cmdWrite,
  input  logic [ADDR_W-1:0]  cmdAddr,
  input  logic [7:0]         cmdData,
  output logic               resValid,
  output logic               resErr,
  output logic [7:0]         resData,
  output logic               sessUp,
  output logic [5:0]         cardType,
  output logic               carrierOn,
  output logic               txStart,
  output logic [ADDR_W+12:0] txFrame,
  output logic [4:0]         txLen,
  input  logic               txDone,
  output logic               rxStart,
  output logic [3:0]         rxLen,
  input  logic               rxDone,
  input  logic [11:0]        rxData,
  input  logic               rawBitValid,
  input  logic               rawBit,
  output logic               ksInit,
  output logic               ksLoad,
  output logic [6:0]         ksIv,
  output logic               ksAdv,
  output logic [1:0]         ksStep
);

  seqStrobe_t stb;
  seqStatus_t sts;

  assign ksIv = SESSION_IV;

  card_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sessStart(sessStart), .cmdStart(cmdStart),
    .cmdWrite(cmdWrite), .txDone(txDone), .rxDone(rxDone),
    .rawBitValid(rawBitValid), .rawBit(rawBit), .sts(sts), .stb(stb),
    .txStart(txStart), .rxStart(rxStart), .rxLen(rxLen), .ksInit(ksInit),
    .ksLoad(ksLoad), .ksAdv(ksAdv), .ksStep(ksStep), .sessUp(sessUp),
    .carrierOn(carrierOn)
  );

  card_seq_dp #(
    .ADDR_W(ADDR_W), .POWER_CYCLES(POWER_CYCLES), .ACK_WINDOW(ACK_WINDOW),
    .WRITE_FLOOR(WRITE_FLOOR), .SESSION_IV(SESSION_IV)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sts(sts), .cmdWrite(cmdWrite),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .rxData(rxData),
    .resValid(resValid), .resErr(resErr), .resData(resData),
    .cardType(cardType), .txFrame(txFrame), .txLen(txLen)
  );

endmodule

// File: rtl/card_session_seq_chk.sv
module card_session_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       txStart,
  input logic       rxStart,
  input logic [4:0] txLen,
  input logic       carrierOn,
  input logic       sessUp,
  input logic [5:0] cardType,
  input logic       resValid,
  input logic       resErr,
  input logic [7:0] resData,
  input logic       ksAdv
);

  AST_TX_NEEDS_CARRIER: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> carrierOn);  // R1

  AST_SESSION_TYPE_KNOWN: assert property (@(posedge clk) disable iff (!rstN)
    sessUp |-> (cardType == 6'h0D || cardType == 6'h1D || cardType == 6'h3D));  // R2

  AST_SESSION_CARRIER: assert property (@(posedge clk) disable iff (!rstN)
    sessUp |-> carrierOn);  // R2

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !carrierOn |-> (!txStart && !rxStart && !ksAdv));  // R3

  AST_RESULT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);  // R5

  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resErr) |-> (resData == 8'h00));  // R6

  AST_FRAME_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> (txLen inside {5'd6, 5'd7, 5'd9, 5'd11, 5'd18, 5'd21, 5'd23}));  // R8

endmodule

bind card_session_seq card_session_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .txStart(txStart), .rxStart(rxStart), .txLen(txLen),
  .carrierOn(carrierOn), .sessUp(sessUp), .cardType(cardType),
  .resValid(resValid), .resErr(resErr), .resData(resData), .ksAdv(ksAdv)
);

// File: tb/card_session_seq_bench.sv
`timescale 1ns/1ps
module card_session_seq_bench;

  localparam int ADDR_W = 10;
  localparam int PWR    = 50;
  localparam int ACK_W  = 60;
  localparam int FW     = ADDR_W + 13;

  logic clk = 1'b0, rstN = 1'b0;
  logic sessStart = 0, cmdStart = 0, cmdWrite = 0;
  logic [ADDR_W-1:0] cmdAddr = '0;
  logic [7:0] cmdData = '0;
  logic resValid, resErr, sessUp, carrierOn, txStart, rxStart;
  logic ksInit, ksLoad, ksAdv;
  logic [7:0] resData;
  logic [5:0] cardType;
  logic [FW-1:0] txFrame;
  logic [4:0] txLen;
  logic [3:0] rxLen;
  logic [6:0] ksIv;
  logic [1:0] ksStep;
  logic txDone = 0, rxDone = 0, rawBitValid = 0, rawBit = 0;
  logic [11:0] rxData = '0;

  always #5 clk = ~clk;

  card_session_seq #(.ADDR_W(ADDR_W), .POWER_CYCLES(PWR), .ACK_WINDOW(ACK_W)) u_card_session_seq (
    .clk(clk), .rstN(rstN), .sessStart(sessStart), .cmdStart(cmdStart),
    .cmdWrite(cmdWrite), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .resValid(resValid), .resErr(resErr), .resData(resData), .sessUp(sessUp),
    .cardType(cardType), .carrierOn(carrierOn), .txStart(txStart),
    .txFrame(txFrame), .txLen(txLen), .txDone(txDone), .rxStart(rxStart),
    .rxLen(rxLen), .rxDone(rxDone), .rxData(rxData), .rawBitValid(rawBitValid),
    .rawBit(rawBit), .ksInit(ksInit), .ksLoad(ksLoad), .ksIv(ksIv),
    .ksAdv(ksAdv), .ksStep(ksStep)
  );

  int checks = 0, errors = 0;
  int evLog[64];
  int evN = 0;
  logic [31:0] frLog[16];
  int frN = 0;
  int resCnt = 0, txDoneCnt = 0;
  logic lastErr = 0;
  logic [7:0] lastData = 0;
  int pwrCycles = 0;
  bit pwrDone = 0;
  int txTimer = 0, rxTimer = 0, rxPendLen = 0;
  logic [5:0] typeReply = 6'h1D;
  logic [11:0] readReply = '0;
  int curAddrSz = 8;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] crc4(input logic [31:0] v, input int n);
    logic [3:0] s;
    logic fb;
    s = 4'h5;
    for (int i = 0; i < n; i++) begin
      fb = s[0] ^ v[i];
      s = s >> 1;
      if (fb) s = s ^ 4'hC;
    end
    return s;
  endfunction

  // Hook models and monitors, all at the falling edge
  always @(negedge clk) begin
    if (txDone) txDone <= 1'b0;
    if (rxDone) rxDone <= 1'b0;
    if (ksInit) begin pwrDone = 1; evLog[evN] = 100; evN++; end
    else if (carrierOn && !pwrDone) pwrCycles++;
    if (ksLoad) begin evLog[evN] = 200; evN++; end
    if (ksAdv)  begin evLog[evN] = int'(ksStep); evN++; end
    if (txStart) begin
      evLog[evN] = 1000 + int'(txLen); evN++;
      frLog[frN] = 32'(txFrame); frN++;
      txTimer = 4;
    end else if (txTimer > 0) begin
      txTimer--;
      if (txTimer == 0) begin txDone <= 1'b1; txDoneCnt++; end
    end
    if (rxStart) begin
      evLog[evN] = 2000 + int'(rxLen); evN++;
      rxPendLen = int'(rxLen);
      rxTimer = 5;
    end else if (rxTimer > 0) begin
      rxTimer--;
      if (rxTimer == 0) begin
        rxData <= (rxPendLen == 12) ? readReply : {6'h00, typeReply};
        rxDone <= 1'b1;
      end
    end
    if (resValid) begin resCnt++; lastErr = resErr; lastData = resData; end
  end

  task automatic clearLogs();
    evN = 0; frN = 0; pwrCycles = 0; pwrDone = 0;
  endtask

  task automatic waitRes(input int r0, input string req);
    int t = 0;
    while (resCnt == r0 && t < 3000) begin @(negedge clk); t++; end
    check(resCnt != r0, req, resCnt, r0 + 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic runSession(input logic [5:0] typ);
    int r0;
    typeReply = typ;
    clearLogs();
    r0 = resCnt;
    @(negedge clk); sessStart = 1;
    @(negedge clk); sessStart = 0;
    waitRes(r0, "R1");
  endtask

  task automatic runRead(input logic [ADDR_W-1:0] addr, input logic [7:0] data, input bit corrupt);
    int r0, len;
    logic [31:0] cmdVal;
    logic [3:0] crc;
    len = curAddrSz + 1;
    cmdVal = ((32'(addr) & ((32'd1 << curAddrSz) - 1)) << 1) | 32'd1;
    crc = crc4((32'(data) << len) | cmdVal, len + 8);
    readReply = {crc ^ (corrupt ? 4'h1 : 4'h0), data};
    clearLogs();
    r0 = resCnt;
    @(negedge clk); cmdStart = 1; cmdWrite = 0; cmdAddr = addr;
    @(negedge clk); cmdStart = 0;
    waitRes(r0, "R5");
    check(frN == 1 && frLog[0] == cmdVal, "R4", int'(frLog[0]), int'(cmdVal));
    check(evN == (corrupt ? 4 : 5) && evLog[0] == 2 && evLog[1] == 1000 + len
          && evLog[2] == 2 && evLog[3] == 2012, "R5", evN, corrupt ? 4 : 5);
    if (corrupt) begin
      check(lastErr == 1 && lastData == 8'h00, "R6", int'({lastErr, lastData}), 'h100);
    end else begin
      check(evLog[4] == 1, "R5", evLog[4], 1);
      check(lastErr == 0 && lastData == data, "R7", int'({lastErr, lastData}), int'(data));
    end
  endtask

  task automatic runWrite(input logic [ADDR_W-1:0] addr, input logic [7:0] data,
                          input int hitAt, input bit expSend, input bit expOk, input string req);
    int r0, len, d0;
    logic [31:0] cmdVal, frame;
    logic [3:0] crc;
    len = curAddrSz + 1;
    cmdVal = (32'(addr) & ((32'd1 << curAddrSz) - 1)) << 1;
    crc = crc4((32'(data) << len) | cmdVal, len + 8);
    frame = cmdVal | (32'(data) << len) | (32'(crc) << (len + 8));
    clearLogs();
    r0 = resCnt;
    d0 = txDoneCnt;
    @(negedge clk); cmdStart = 1; cmdWrite = 1; cmdAddr = addr; cmdData = data;
    @(negedge clk); cmdStart = 0; cmdWrite = 0;
    if (expSend) begin
      for (int t = 0; t < 200 && txDoneCnt == d0; t++) @(negedge clk);
      for (int i = 1; i <= ACK_W + 3 && resCnt == r0; i++) begin
        repeat (3) @(negedge clk);
        rawBitValid = 1; rawBit = (i == hitAt);
        @(negedge clk);
        rawBitValid = 0; rawBit = 0;
      end
    end
    waitRes(r0, req);
    if (expSend) begin
      check(frN == 1 && frLog[0] == frame, "R8", int'(frLog[0]), int'(frame));
      check(evN >= 3 && evLog[0] == 2 && evLog[1] == 1000 + len + 12 && evLog[2] == 3,
            "R8", evLog[1], 1000 + len + 12);
    end else begin
      check(frN == 0 && evN == 0, "R10", frN, 0);
    end
    check(lastErr == !expOk, req, int'(lastErr), int'(!expOk));
  endtask

  localparam logic [16:0] RD_VEC [6] = '{
    {8'h00, 8'hA5, 1'b0}, {8'h7F, 8'h3C, 1'b0}, {8'hFF, 8'h00, 1'b0},
    {8'h12, 8'hFF, 1'b1}, {8'h80, 8'h5A, 1'b0}, {8'h33, 8'hC3, 1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!sessUp && !carrierOn && !resValid && !txStart && !ksAdv && !ksInit,
          "R11", int'({sessUp, carrierOn, resValid, txStart}), 0);
    rstN = 1;
    @(negedge clk);
    check(!resErr && resData == 8'h00 && !rxStart && !ksLoad, "R11",
          int'({resErr, resData}), 0);

    // R12 command with no session
    clearLogs();
    begin
      int r0 = resCnt;
      @(negedge clk); cmdStart = 1; cmdAddr = 10'h20;
      @(negedge clk); cmdStart = 0;
      repeat (20) @(negedge clk);
      check(resCnt == r0 && evN == 0, "R12", resCnt - r0 + evN, 0);
    end

    // R1 R2 handshake on the mid-size card
    runSession(6'h1D);
    check(pwrCycles == PWR, "R1", pwrCycles, PWR);
    check(evN == 7 && evLog[0] == 100 && evLog[1] == 1007 && evLog[2] == 200
          && evLog[3] == 2 && evLog[4] == 2006 && evLog[5] == 3 && evLog[6] == 1006,
          "R1", evN, 7);
    check(frLog[0] == 32'h55 && ksIv == 7'h55, "R1", int'(frLog[0]), 'h55);
    check(frLog[1] == 32'h39, "R2", int'(frLog[1]), 'h39);
    check(sessUp && !lastErr && cardType == 6'h1D, "R2", int'(cardType), 'h1D);
    curAddrSz = 8;

    // Read table: R4 R5 R6 R7
    for (int i = 0; i < 6; i++)
      runRead(10'(RD_VEC[i][16:9]), RD_VEC[i][8:1], RD_VEC[i][0]);

    // R8 R9 writes with acknowledge timing
    runWrite(10'h20, 8'h5A, 3, 1, 1, "R9");
    runWrite(10'hC1, 8'h96, ACK_W, 1, 1, "R9");
    runWrite(10'h07, 8'h11, ACK_W + 1, 1, 0, "R9");
    // R10 protected addresses
    runWrite(10'h04, 8'hEE, 1, 0, 0, "R10");
    runWrite(10'h05, 8'h3E, 1, 1, 1, "R10");

    // Smallest card: R2 acknowledge and R4 masking
    runSession(6'h0D);
    check(frN == 2 && frLog[1] == 32'h19 && cardType == 6'h0D, "R2", int'(frLog[1]), 'h19);
    curAddrSz = 5;
    runRead(10'h35, 8'h6B, 0);

    // Largest card
    runSession(6'h3D);
    check(frN == 2 && frLog[1] == 32'h39 && sessUp, "R2", int'(frLog[1]), 'h39);
    curAddrSz = 10;
    runRead(10'h3FF, 8'h81, 0);
    runWrite(10'h2A5, 8'h0F, 2, 1, 1, "R9");

    // R3 unknown type
    runSession(6'h2A);
    check(lastErr == 1, "R3", int'(lastErr), 1);
    check(!sessUp && !carrierOn, "R3", int'({sessUp, carrierOn}), 0);
    check(evN == 5 && frN == 1 && evLog[4] == 2006, "R3", evN, 5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule